// File: doc/BRIEF.md
# Operand Offset and Segment Selection Unit

This unit forms the 16-bit offset of a memory operand and decides which of four segment registers that operand is addressed through. A requester presents an addressing-mode code, base and index register choices, the current values of the two base registers and the two index registers, a displacement with a width flag, an access kind, and an optional explicit segment choice. All of these are qualified by a single `in_valid` strobe.

The offset is the sum, modulo 2^16, of the components the mode calls for: displacement, base, index, or a combination. A short displacement is sign-extended before the add. The segment is derived from the access kind and from whether the frame-pointer register is the base. An explicit segment choice overrides it, except for instruction fetches, stack push/pop traffic and string destinations, which keep their fixed segment.

One cycle after the strobe, the result is held in registers and `out_valid` is raised for one cycle. Reserved mode codes, and register-indirect requests with neither register enabled, raise `illegal` and return offset zero.

Top module: `ea_seg_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. A synchronous active-high `rst` clears `out_valid`. `offset`, `seg` and `illegal` are registered and belong to the request of the previous cycle.
- R2: Mode codes: 0 = displacement only, 2 = base + displacement, 3 = index + displacement, 4 = base + index, 5 = base + index + displacement. The base is BX when `base_sel`=0 and BP when 1. The index is SI when `idx_sel`=0 and DI when 1.
- R3: The offset sum wraps modulo 2^16, so operands with the top bit set behave as negative values.
- R4: When `disp_wide`=0, only `disp[7:0]` is used, sign-extended to 16 bits. Mode 0 always uses all 16 bits of `disp`, whatever `disp_wide` is.
- R5: Segment encoding is 00 = ES, 01 = CS, 10 = SS, 11 = DS. Access kind 0 (instruction fetch) always yields CS, and the override is ignored.
- R6: Access kind 1 (stack push/pop) always yields SS, and the override is ignored.
- R7: Access kind 3 (string destination) always yields ES, and the override is ignored.
- R8: Access kind 2 (data) without override yields SS when the mode uses a base and `base_sel`=1 (BP). Otherwise it yields DS.
- R9: Access kind 2 with `ovr_valid`=1 yields `ovr_code` (same encoding as R5).
- R10: Mode codes 6 and 7 are reserved. They, and mode 1 with both `base_en` and `idx_en` low, give `illegal`=1 and offset 0. Every other request gives `illegal`=0.
- R11: Mode 1 (register indirect) returns the selected base when `base_en`=1, else the selected index when `idx_en`=1. In that mode the displacement is not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code |
| base_en | input | 1 | Register-indirect: use the base register |
| base_sel | input | 1 | Base choice: 0 = BX, 1 = BP |
| idx_en | input | 1 | Register-indirect: use the index register |
| idx_sel | input | 1 | Index choice: 0 = SI, 1 = DI |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| disp | input | 16 | Displacement |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| access | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| ovr_valid | input | 1 | Explicit segment choice present |
| ovr_code | input | 2 | Explicit segment, encoded as in R5 |
| out_valid | output | 1 | Result valid |
| offset | output | 16 | Operand offset |
| seg | output | 2 | Selected segment |
| illegal | output | 1 | Illegal mode flag |

## Verification
Every result is due exactly one clock after its strobe. The bench drives each request just after a falling edge, and the rising edge that follows captures it. At the next falling edge, the bench compares `offset`, `seg`, `illegal` and `out_valid` with the model's prediction for that request. Cycles with no strobe are also compared, to confirm that `out_valid` is low there.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int WORD_W  = 16;
  localparam int SHORT_W = 8;
  localparam int SEG_W   = 2;
  localparam int MODE_W  = 3;
  localparam int ACC_W   = 2;

  typedef enum logic [SEG_W-1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_e;

  typedef enum logic [MODE_W-1:0] {
    M_DIRECT   = 3'd0,
    M_REGIND   = 3'd1,
    M_BASED    = 3'd2,
    M_INDEXED  = 3'd3,
    M_BASE_IDX = 3'd4,
    M_BIDX_D   = 3'd5,
    M_RSV6     = 3'd6,
    M_RSV7     = 3'd7
  } mode_e;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_STRD  = 2'd3
  } acc_e;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [WORD_W-1:0] disp,
  input  logic              wide,
  input  logic              force_wide,
  output logic [WORD_W-1:0] ext
);
  localparam int FILL_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] short_ext;

  generate
    if (FILL_W > 0) begin : g_fill
      assign short_ext = {{FILL_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_nofill
      assign short_ext = disp;
    end
  endgenerate

  always_comb begin
    if (wide || force_wide) ext = disp;
    else                    ext = short_ext;
  end
endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              base_en,
  input  logic              base_sel,
  input  logic              idx_en,
  input  logic              idx_sel,
  input  logic [W-1:0]      reg_bx,
  input  logic [W-1:0]      reg_bp,
  input  logic [W-1:0]      reg_si,
  input  logic [W-1:0]      reg_di,
  input  logic [W-1:0]      disp_ext,
  output logic [W-1:0]      offset,
  output logic              illegal,
  output logic              frame_base
);
  logic [W-1:0] base_v, idx_v;
  logic         use_b, use_x, use_d;

  assign base_v = base_sel ? reg_bp : reg_bx;
  assign idx_v  = idx_sel  ? reg_di : reg_si;

  always_comb begin
    use_b   = 1'b0;
    use_x   = 1'b0;
    use_d   = 1'b0;
    illegal = 1'b0;
    unique case (mode_e'(mode))
      M_DIRECT:   use_d = 1'b1;
      M_REGIND: begin
        if (base_en)     use_b = 1'b1;
        else if (idx_en) use_x = 1'b1;
        else             illegal = 1'b1;
      end
      M_BASED:    begin use_b = 1'b1; use_d = 1'b1; end
      M_INDEXED:  begin use_x = 1'b1; use_d = 1'b1; end
      M_BASE_IDX: begin use_b = 1'b1; use_x = 1'b1; end
      M_BIDX_D:   begin use_b = 1'b1; use_x = 1'b1; use_d = 1'b1; end
      default:    illegal = 1'b1;
    endcase
  end

  always_comb begin
    offset = (use_b ? base_v : '0) + (use_x ? idx_v : '0) + (use_d ? disp_ext : '0);
    if (illegal) offset = '0;
  end

  assign frame_base = use_b & base_sel;
endmodule

// File: rtl/ea_seg_select.sv
module ea_seg_select
  import ea_pkg::*;
(
  input  logic [ACC_W-1:0] access,
  input  logic             frame_base,
  input  logic             ovr_valid,
  input  logic [SEG_W-1:0] ovr_code,
  output logic [SEG_W-1:0] seg
);
  logic [SEG_W-1:0] data_default;

  assign data_default = frame_base ? SEG_SS : SEG_DS;

  always_comb begin
    unique case (acc_e'(access))
      ACC_FETCH: seg = SEG_CS;
      ACC_STACK: seg = SEG_SS;
      ACC_STRD:  seg = SEG_ES;
      default:   seg = ovr_valid ? ovr_code : data_default;
    endcase
  end
endmodule

// File: rtl/ea_seg_unit.sv
module ea_seg_unit
  import ea_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int SW = SHORT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       mode,
  input  logic             base_en,
  input  logic             base_sel,
  input  logic             idx_en,
  input  logic             idx_sel,
  input  logic [W-1:0]     reg_bx,
  input  logic [W-1:0]     reg_bp,
  input  logic [W-1:0]     reg_si,
  input  logic [W-1:0]     reg_di,
  input  logic [W-1:0]     disp,
  input  logic             disp_wide,
  input  logic [1:0]       access,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_code,
  output logic             out_valid,
  output logic [W-1:0]     offset,
  output logic [1:0]       seg,
  output logic             illegal
);
  logic [W-1:0]     d_ext, off_c;
  logic             ill_c, fb_c;
  logic [SEG_W-1:0] seg_c;
  logic             direct_m;

  assign direct_m = (mode == M_DIRECT);

  ea_disp_ext #(.WORD_W(W), .SHORT_W(SW)) u_ext (
    .disp(disp), .wide(disp_wide), .force_wide(direct_m), .ext(d_ext)
  );

  ea_offset_calc #(.W(W)) u_off (
    .mode(mode), .base_en(base_en), .base_sel(base_sel),
    .idx_en(idx_en), .idx_sel(idx_sel),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp_ext(d_ext), .offset(off_c), .illegal(ill_c), .frame_base(fb_c)
  );

  ea_seg_select u_seg (
    .access(access), .frame_base(fb_c),
    .ovr_valid(ovr_valid), .ovr_code(ovr_code), .seg(seg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      offset    <= '0;
      seg       <= SEG_DS;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        offset  <= off_c;
        seg     <= seg_c;
        illegal <= ill_c;
      end
    end
  end
endmodule

// File: rtl/ea_seg_unit_chk.sv
module ea_seg_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   access,
  input logic         ovr_valid,
  input logic [1:0]   ovr_code,
  input logic         out_valid,
  input logic [W-1:0] offset,
  input logic [1:0]   seg,
  input logic         illegal
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
  a_r5_fetch_cs: assert property (@(posedge clk) disable iff (rst)
    (in_valid && access == 2'd0) |=> seg == 2'b01);
  a_r6_stack_ss: assert property (@(posedge clk) disable iff (rst)
    (in_valid && access == 2'd1) |=> seg == 2'b10);
  a_r7_strd_es: assert property (@(posedge clk) disable iff (rst)
    (in_valid && access == 2'd3) |=> seg == 2'b00);
  a_r9_override: assert property (@(posedge clk) disable iff (rst)
    (in_valid && access == 2'd2 && ovr_valid) |=> seg == $past(ovr_code));
  a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> offset == '0);
endmodule

bind ea_seg_unit ea_seg_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .access(access),
  .ovr_valid(ovr_valid), .ovr_code(ovr_code), .out_valid(out_valid),
  .offset(offset), .seg(seg), .illegal(illegal)
);

// File: tb/ea_seg_unit_bench.sv
module ea_seg_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, base_en, base_sel, idx_en, idx_sel, disp_wide, ovr_valid;
  logic [2:0]  mode;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, disp;
  logic [1:0]  access, ovr_code;
  logic        out_valid, illegal;
  logic [15:0] offset;
  logic [1:0]  seg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_seg_unit u_ea_seg_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .base_en(base_en), .base_sel(base_sel), .idx_en(idx_en), .idx_sel(idx_sel),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp(disp), .disp_wide(disp_wide), .access(access),
    .ovr_valid(ovr_valid), .ovr_code(ovr_code),
    .out_valid(out_valid), .offset(offset), .seg(seg), .illegal(illegal)
  );

  // behavioural model of one request
  task automatic model(output int e_off, output int e_seg, output bit e_ill);
    int d, b, x, s;
    bit bp_base;
    d = disp_wide ? int'(disp) : ((int'(disp[7:0]) ^ 128) - 128);
    b = base_sel ? int'(reg_bp) : int'(reg_bx);
    x = idx_sel ? int'(reg_di) : int'(reg_si);
    e_ill = 0; bp_base = 0; s = 0;
    case (mode)
      3'd0: s = int'(disp);
      3'd1: if (base_en) begin s = b; bp_base = base_sel; end
            else if (idx_en) s = x;
            else e_ill = 1;
      3'd2: begin s = b + d; bp_base = base_sel; end
      3'd3: s = x + d;
      3'd4: begin s = b + x; bp_base = base_sel; end
      3'd5: begin s = b + x + d; bp_base = base_sel; end
      default: e_ill = 1;
    endcase
    e_off = e_ill ? 0 : (s & 16'hFFFF);
    case (access)
      2'd0: e_seg = 1;
      2'd1: e_seg = 2;
      2'd3: e_seg = 0;
      default: e_seg = ovr_valid ? int'(ovr_code) : (bp_base ? 2 : 3);
    endcase
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set(int m, bit be, bit bs, bit ie, bit is_, int dv, bit w, int acc, bit ov, int oc);
    mode = 3'(m); base_en = be; base_sel = bs; idx_en = ie; idx_sel = is_;
    disp = 16'(dv); disp_wide = w; access = 2'(acc); ovr_valid = ov; ovr_code = 2'(oc);
  endtask

  // drive one request after a falling edge, compare at the next falling edge
  task automatic req(string tag);
    int eo, es;
    bit ei;
    model(eo, es, ei);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 valid"}, int'(out_valid), 1);
    chk({tag, " offset"}, int'(offset), eo);
    chk({tag, " seg"}, int'(seg), es);
    chk({tag, " illegal"}, int'(illegal), int'(ei));
  endtask

  initial begin
    rst = 1; in_valid = 0;
    reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0400;
    set(0, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 idle valid", int'(out_valid), 0);

    set(0, 0, 0, 0, 0, 16'h1234, 0, 2, 0, 0); req("R4 R2 direct full disp");
    set(2, 0, 0, 0, 0, 16'h0080, 0, 2, 0, 0); req("R4 R2 based BX neg short");
    set(2, 0, 1, 0, 0, 16'h0005, 1, 2, 0, 0); req("R8 R2 based BP SS");
    set(3, 0, 0, 0, 1, 16'h00FF, 0, 2, 0, 0); req("R4 R2 indexed DI");
    set(4, 0, 0, 0, 0, 0, 0, 2, 0, 0);         req("R2 R8 base idx DS");
    set(5, 0, 1, 0, 1, 16'h0010, 1, 2, 0, 0); req("R2 R8 bidx disp BP");
    set(1, 1, 1, 1, 0, 16'h7777, 1, 2, 0, 0); req("R11 regind base BP");
    set(1, 0, 0, 1, 0, 16'h7777, 1, 2, 0, 0); req("R11 regind index SI");
    set(1, 0, 1, 0, 0, 0, 0, 2, 0, 0);         req("R10 regind none");
    set(6, 1, 0, 1, 0, 5, 1, 2, 0, 0);         req("R10 reserved 6");
    set(7, 1, 0, 1, 0, 5, 1, 2, 0, 0);         req("R10 reserved 7");
    set(2, 0, 1, 0, 0, 0, 1, 0, 1, 3);         req("R5 fetch ovr ignored");
    set(4, 0, 0, 0, 0, 0, 0, 1, 1, 0);         req("R6 stack ovr ignored");
    set(3, 0, 0, 0, 1, 0, 0, 3, 1, 3);         req("R7 strdest ovr ignored");
    set(2, 0, 1, 0, 0, 0, 0, 2, 1, 0);         req("R9 override ES on BP");
    set(0, 0, 0, 0, 0, 16'h0100, 0, 2, 1, 1);  req("R9 override CS");
    reg_bx = 16'hFFF0; reg_si = 16'h8000;
    set(5, 0, 0, 0, 0, 16'h8020, 1, 2, 0, 0);  req("R3 wrap");
    set(0, 0, 0, 0, 0, 16'h0000, 0, 2, 0, 0);
    @(negedge clk);
    chk("R1 gap valid", int'(out_valid), 0);

    for (int i = 0; i < 300; i++) begin
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
      set(int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          int'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom), int'($urandom % 4));
      req("R2 R3 R8 random");
    end

    rst = 1; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R1 reset over strobe", int'(out_valid), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule